// File: doc/BRIEF.md
# Timed Key Unlock Call Gate

This block sits beside a small 8-bit processor core and decides whether a special subroutine call into a protected programming service may proceed. It watches the core's data-bus writes. When the unlock byte lands in the key register, it opens a short window that is measured in instruction cycles. A decoded protected call is honoured only while that window is open. Each key write authorises at most one call. Any interrupt that the core services in the meantime, or any wrong byte written to the key register, closes the window early.

An accepted call puts the block into protected mode, which lasts until the core signals its return from the service. While in that mode, the block holds back interrupt delivery with its own mask and never touches the software global-enable flag. Each source can keep at most one request pending, so repeated firings of a source collapse into that one request. When protected mode ends, the kept requests are presented again, gated by the global enable.

Top module: `key_call_gate`

## Requirements
- R1: After reset, the window is closed, `prot_mode`, `call_ok` and `call_rej` are 0, and `irq_out` is all zeros.
- R2: A write of 0x98 to data address 0xE2 (`bus_we`=1) opens the window on the next cycle (`key_armed`=1). A write of 0x98 to any other address leaves the window state unchanged.
- R3: The window closes once six `icyc_stb` pulses have been counted after the key write. A call decoded in a cycle that begins with the window open is accepted, even if a strobe arrives in that same cycle. A call decoded after the sixth strobe is rejected.
- R4: Writing any value other than 0x98 to address 0xE2 closes an open window on the next cycle.
- R5: An `irq_taken` pulse closes an open window on the next cycle, so a later call is rejected.
- R6: An accepted call produces a one-cycle `call_ok` pulse, sets `prot_mode` on the same edge, and closes the window. A second call then needs a new key write.
- R7: A call decoded while the window is closed produces a one-cycle `call_rej` pulse, does not set `prot_mode`, and never coincides with `call_ok`.
- R8: A `boot_ret` pulse clears `prot_mode` on the next edge, unless an accepted call arrives in the same cycle.
- R9: While `prot_mode` is 1, `irq_out` is all zeros and `irq_ack` has no effect. Each source keeps at most one pending request, so further firings of a source that is already pending are lost.
- R10: Outside protected mode, `irq_out[i]` equals pending bit i ANDed with `gie`. An `irq_ack[i]` pulse clears pending bit i, and a new `irq_src[i]` pulse in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Data-bus write strobe |
| bus_addr | input | 8 | Data-bus write address |
| bus_wdata | input | 8 | Data-bus write data |
| icyc_stb | input | 1 | One pulse per completed instruction cycle |
| call_dec | input | 1 | Protected call instruction decoded this cycle |
| irq_taken | input | 1 | Core is servicing an interrupt |
| boot_ret | input | 1 | Return from the protected service |
| gie | input | 1 | Software global interrupt enable (read only) |
| irq_src | input | 4 | Per-source interrupt event pulses |
| irq_ack | input | 4 | Per-source acknowledge |
| irq_out | output | 4 | Requests presented to the core |
| key_armed | output | 1 | Unlock window currently open |
| call_ok | output | 1 | One-cycle pulse: call accepted |
| call_rej | output | 1 | One-cycle pulse: call rejected |
| prot_mode | output | 1 | Protected execution active |

## Verification
Directed sequences place a call after five strobes and after six strobes, so the bench can tell whether the window closes at the right count or one strobe off. Other directed sequences close the window early with a wrong key byte or a serviced interrupt, and write the right byte to the wrong address; each shows whether that one cause is decoded on its own. A protected-mode sequence fires the same source twice, acknowledges it during the mode, and releases it with the global enable low and then high; this separates masking from dropping and shows where gating by the enable takes place. Biased random traffic then mixes key writes, strobes, calls, returns and interrupts in the same cycle to exercise the priority between arm, clear and count.

// File: rtl/kcg_pkg.sv
package kcg_pkg;

  typedef enum logic [1:0] {
    KEY_NONE = 2'd0,
    KEY_GOOD = 2'd1,
    KEY_BAD  = 2'd2
  } key_evt_e;

  // Classify one bus write against the key register.
  function automatic key_evt_e key_classify(input logic we, input logic [7:0] addr,
                                            input logic [7:0] data,
                                            input logic [7:0] key_addr,
                                            input logic [7:0] key_val);
    if (!we || addr != key_addr) return KEY_NONE;
    return (data == key_val) ? KEY_GOOD : KEY_BAD;
  endfunction

  // Window counter step: arming wins, then clearing, then counting down.
  function automatic int win_step(input int cnt, input key_evt_e ev, input logic clr,
                                  input logic stb, input int win_len);
    if (ev == KEY_GOOD) return win_len;
    if (ev == KEY_BAD || clr) return 0;
    if (stb && cnt != 0) return cnt - 1;
    return cnt;
  endfunction

endpackage

// File: rtl/kcg_key_window.sv
module kcg_key_window
  import kcg_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  KEY_ADDR = 8'hE2,
  parameter logic [7:0]  KEY_VAL  = 8'h98,
  parameter int          WIN_CYC  = 6,
  localparam int         CNT_W    = $clog2(WIN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              icyc_stb,
  input  logic              irq_taken,
  input  logic              call_acc,
  output logic              win_open,
  output logic [CNT_W-1:0]  win_cnt,
  output logic              key_good,
  output logic              key_bad
);

  key_evt_e         ev;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    ev       = key_classify(bus_we, 8'(bus_addr), 8'(bus_wdata), KEY_ADDR, KEY_VAL);
    key_good = (ev == KEY_GOOD);
    key_bad  = (ev == KEY_BAD);
    cnt_nxt  = CNT_W'(win_step(int'(win_cnt), ev, irq_taken | call_acc, icyc_stb, WIN_CYC));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) win_cnt <= '0;
    else        win_cnt <= cnt_nxt;
  end

  assign win_open = (win_cnt != '0);

endmodule

// File: rtl/kcg_call_ctl.sv
module kcg_call_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic call_dec,
  input  logic win_open,
  input  logic boot_ret,
  output logic call_acc,
  output logic call_ok,
  output logic call_rej,
  output logic prot_mode
);

  logic call_deny;

  always_comb begin
    call_acc  = call_dec & win_open;
    call_deny = call_dec & ~win_open;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      call_ok   <= 1'b0;
      call_rej  <= 1'b0;
      prot_mode <= 1'b0;
    end else begin
      call_ok  <= call_acc;
      call_rej <= call_deny;
      if (call_acc)      prot_mode <= 1'b1;
      else if (boot_ret) prot_mode <= 1'b0;
    end
  end

endmodule

// File: rtl/kcg_irq_gate.sv
module kcg_irq_gate #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_mode,
  input  logic             gie,
  input  logic [N_IRQ-1:0] irq_src,
  input  logic [N_IRQ-1:0] irq_ack,
  output logic [N_IRQ-1:0] irq_out,
  output logic [N_IRQ-1:0] pend
);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    logic clr;
    assign clr = irq_ack[i] & ~prot_mode;

    always_ff @(posedge clk) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (irq_src[i]) pend[i] <= 1'b1;
      else if (clr)        pend[i] <= 1'b0;
    end

    assign irq_out[i] = pend[i] & gie & ~prot_mode;
  end

endmodule

// File: rtl/key_call_gate.sv
module key_call_gate
  import kcg_pkg::*;
#(
  parameter int          N_IRQ    = 4,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  KEY_ADDR = 8'hE2,
  parameter logic [7:0]  KEY_VAL  = 8'h98,
  parameter int          WIN_CYC  = 6,
  localparam int         CNT_W    = $clog2(WIN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              icyc_stb,
  input  logic              call_dec,
  input  logic              irq_taken,
  input  logic              boot_ret,
  input  logic              gie,
  input  logic [N_IRQ-1:0]  irq_src,
  input  logic [N_IRQ-1:0]  irq_ack,
  output logic [N_IRQ-1:0]  irq_out,
  output logic              key_armed,
  output logic              call_ok,
  output logic              call_rej,
  output logic              prot_mode
);

  logic             win_open;
  logic [CNT_W-1:0] win_cnt;
  logic             key_good;
  logic             key_bad;
  logic             call_acc;
  logic [N_IRQ-1:0] pend;

  kcg_key_window #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_VAL(KEY_VAL), .WIN_CYC(WIN_CYC)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .icyc_stb(icyc_stb), .irq_taken(irq_taken),
    .call_acc(call_acc), .win_open(win_open), .win_cnt(win_cnt),
    .key_good(key_good), .key_bad(key_bad)
  );

  kcg_call_ctl u_call (
    .clk(clk), .rst_n(rst_n), .call_dec(call_dec), .win_open(win_open),
    .boot_ret(boot_ret), .call_acc(call_acc), .call_ok(call_ok),
    .call_rej(call_rej), .prot_mode(prot_mode)
  );

  kcg_irq_gate #(.N_IRQ(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .gie(gie),
    .irq_src(irq_src), .irq_ack(irq_ack), .irq_out(irq_out), .pend(pend)
  );

  assign key_armed = win_open;

endmodule

// File: rtl/kcg_chk.sv
module kcg_chk #(
  parameter int         N_IRQ    = 4,
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] KEY_ADDR = 8'hE2,
  parameter logic [7:0] KEY_VAL  = 8'h98,
  parameter int         WIN_CYC  = 6,
  parameter int         CNT_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              call_dec,
  input logic              irq_taken,
  input logic              boot_ret,
  input logic              gie,
  input logic [N_IRQ-1:0]  irq_out,
  input logic              win_open,
  input logic [CNT_W-1:0]  win_cnt,
  input logic              call_ok,
  input logic              call_rej,
  input logic              prot_mode
);

  logic kw_good, kw_bad;
  assign kw_good = bus_we && (8'(bus_addr) == KEY_ADDR) && (8'(bus_wdata) == KEY_VAL);
  assign kw_bad  = bus_we && (8'(bus_addr) == KEY_ADDR) && (8'(bus_wdata) != KEY_VAL);

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kw_good |=> win_open && (int'(win_cnt) == WIN_CYC));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_cnt) <= WIN_CYC);
  // R4
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kw_bad |=> !win_open);
  // R5
  taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken && !kw_good |=> !win_open);
  // R6
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_dec && win_open && !kw_good |=> call_ok && prot_mode && !win_open);
  // R6
  prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_mode) |-> call_ok);
  // R7
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_dec && !win_open |=> call_rej && !call_ok);
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_ok && call_rej));
  // R8
  ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_ret && !(call_dec && win_open) |=> !prot_mode);
  // R9
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_mode |-> irq_out == '0);
  // R10
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> irq_out == '0);

endmodule

bind key_call_gate kcg_chk #(
  .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
  .KEY_VAL(KEY_VAL), .WIN_CYC(WIN_CYC), .CNT_W(CNT_W)
) u_kcg_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .call_dec(call_dec), .irq_taken(irq_taken),
  .boot_ret(boot_ret), .gie(gie), .irq_out(irq_out), .win_open(win_open),
  .win_cnt(win_cnt), .call_ok(call_ok), .call_rej(call_rej), .prot_mode(prot_mode)
);

// File: tb/tb_key_call_gate.sv
module tb_key_call_gate;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       icyc_stb, call_dec, irq_taken, boot_ret, gie;
  logic [3:0] irq_src, irq_ack;
  logic [3:0] irq_out;
  logic       key_armed, call_ok, call_rej, prot_mode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Bench's own view of the block.
  int       m_left;
  bit       m_prot, m_ok, m_rej;
  bit [3:0] m_pend;

  always #10 clk = ~clk;

  key_call_gate dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .icyc_stb(icyc_stb), .call_dec(call_dec),
    .irq_taken(irq_taken), .boot_ret(boot_ret), .gie(gie), .irq_src(irq_src),
    .irq_ack(irq_ack), .irq_out(irq_out), .key_armed(key_armed),
    .call_ok(call_ok), .call_rej(call_rej), .prot_mode(prot_mode)
  );

  function automatic bit [3:0] exp_irq(bit prot, bit [3:0] pend, bit g);
    if (prot || !g) return 4'b0;
    return pend;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    bus_we = 0; bus_addr = 8'h00; bus_wdata = 8'h00;
    icyc_stb = 0; call_dec = 0; irq_taken = 0; boot_ret = 0;
    irq_src = 4'b0; irq_ack = 4'b0;
  endtask

  task automatic model_edge();
    bit kg, kb, open, acc;
    kg   = bus_we && bus_addr == 8'hE2 && bus_wdata == 8'h98;
    kb   = bus_we && bus_addr == 8'hE2 && bus_wdata != 8'h98;
    open = (m_left > 0);
    acc  = call_dec && open;
    for (int i = 0; i < 4; i++)
      if (irq_src[i]) m_pend[i] = 1;
      else if (irq_ack[i] && !m_prot) m_pend[i] = 0;
    if (kg) m_left = 6;
    else if (kb || irq_taken || acc) m_left = 0;
    else if (icyc_stb && open) m_left = m_left - 1;
    m_ok  = acc;
    m_rej = call_dec && !open;
    if (acc) m_prot = 1;
    else if (boot_ret) m_prot = 0;
  endtask

  // One clock: inputs already driven, update model at the edge, compare at negedge.
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(key_armed == (m_left > 0), "R3 window", key_armed, m_left > 0);
    check(call_ok == m_ok, "R6 call_ok", call_ok, m_ok);
    check(call_rej == m_rej, "R7 call_rej", call_rej, m_rej);
    check(prot_mode == m_prot, "R8 prot_mode", prot_mode, m_prot);
    check(irq_out == exp_irq(m_prot, m_pend, gie), "R10 irq_out", irq_out,
          exp_irq(m_prot, m_pend, gie));
    quiet();
  endtask

  task automatic key_wr(input bit [7:0] a, input bit [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    gie = 1;
    rst_n = 0;
    m_left = 0; m_prot = 0; m_ok = 0; m_rej = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(key_armed == 0 && prot_mode == 0 && call_ok == 0 && call_rej == 0 && irq_out == 0,
          "R1 reset", {key_armed, prot_mode, call_ok, call_rej, irq_out}, 0);
    rst_n = 1;

    // R2: right byte at the wrong address does nothing
    key_wr(8'h55, 8'h98);
    check(key_armed == 0, "R2 wrong addr", key_armed, 0);
    key_wr(8'hE2, 8'h98);
    check(key_armed == 1, "R2 armed", key_armed, 1);

    // R3: five strobes, call in the cycle that also carries the sixth
    repeat (5) begin icyc_stb = 1; step(); end
    check(key_armed == 1, "R3 still open after 5", key_armed, 1);
    call_dec = 1; icyc_stb = 1; step();
    check(call_ok == 1 && prot_mode == 1, "R6 accepted", {call_ok, prot_mode}, 3);
    check(key_armed == 0, "R6 window used", key_armed, 0);
    call_dec = 1; step();
    check(call_rej == 1 && call_ok == 0, "R6 second call rejected", {call_ok, call_rej}, 1);

    boot_ret = 1; step();
    check(prot_mode == 0, "R8 return", prot_mode, 0);

    // R3: six strobes close the window
    key_wr(8'hE2, 8'h98);
    repeat (6) begin icyc_stb = 1; step(); end
    check(key_armed == 0, "R3 expired", key_armed, 0);
    call_dec = 1; step();
    check(call_rej == 1 && prot_mode == 0, "R7 late call", {call_rej, prot_mode}, 2);

    // R4: wrong byte closes the window
    key_wr(8'hE2, 8'h98);
    key_wr(8'hE2, 8'h97);
    check(key_armed == 0, "R4 bad key", key_armed, 0);

    // R5: interrupt serviced before the call
    key_wr(8'hE2, 8'h98);
    irq_taken = 1; step();
    call_dec = 1; step();
    check(call_rej == 1 && prot_mode == 0, "R5 key expired", {call_rej, prot_mode}, 2);

    // R9: masking and loss of duplicate events
    key_wr(8'hE2, 8'h98);
    call_dec = 1; step();
    irq_src = 4'b0001; step();
    check(irq_out == 0, "R9 masked", irq_out, 0);
    irq_src = 4'b0001; step();
    irq_ack = 4'b0001; step();
    check(irq_out == 0, "R9 ack ignored", irq_out, 0);
    gie = 0; boot_ret = 1; step();
    check(irq_out == 0, "R10 gie low", irq_out, 0);
    gie = 1; step();
    check(irq_out == 4'b0001, "R9 kept request", irq_out, 1);
    irq_ack = 4'b0001; step();
    check(irq_out == 0, "R9 duplicate lost", irq_out, 0);
    irq_src = 4'b0100; irq_ack = 4'b0100; step();
    check(irq_out == 4'b0100, "R10 src beats ack", irq_out, 4);

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 100 < 20) begin
        bus_we = 1;
        bus_addr = ($urandom % 100 < 75) ? 8'hE2 : 8'($urandom);
        bus_wdata = ($urandom % 100 < 70) ? 8'h98 : 8'($urandom);
      end
      icyc_stb  = ($urandom % 2) == 0;
      call_dec  = ($urandom % 100) < 15;
      irq_taken = ($urandom % 100) < 5;
      boot_ret  = ($urandom % 100) < 8;
      gie       = ($urandom % 100) < 75;
      for (int i = 0; i < 4; i++) begin
        irq_src[i] = ($urandom % 100) < 10;
        irq_ack[i] = ($urandom % 100) < 30;
      end
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule